// File: doc/BRIEF.md
# Stream-to-Memory Write Adapter

This block drains a flow-controlled word stream coming out of a processing function and stores it, one word per location, into a single memory bank at consecutive word addresses. Software arms a transfer by programming a destination word address and a word count, then writing the start bit. Each accepted beat becomes one write request, and the request is held until the memory acknowledges it. While a request is outstanding the adapter holds the producer off, so at most one word is ever in flight.

Progress is visible through a running count of acknowledged writes. A completion flag sets when the final write is acknowledged, so the host can poll until the result buffer is complete. The register window sits at a fixed base address, which is set by a parameter. Beats beyond the programmed count stay blocked until software arms the next transfer.

Top module: `stwa_top`

## Requirements
- R1: The register window answers only at word addresses BASE+0..BASE+3 (default BASE 0x5200): +0 control (bit0 start, bit1 busy, bit2 done, bit0 reads 0), +1 destination word address (20 bits), +2 word count (16 bits), +3 acknowledged-write count (read-only). Writes elsewhere change nothing, and reads elsewhere return 0.
- R2: Writing 1 to control bit0 while idle clears the acknowledged count and done, and sets busy on the next clock edge. With a programmed count of 0, done sets at once, busy stays low, and no beat is accepted.
- R3: Beat n of a transfer (n counted from 0) produces one write request with address (destination + n) mod 2^20 and the beat's data. The request is raised on the edge after the beat is accepted and is held with stable address and data until it is acknowledged.
- R4: s_ready is low while a request is pending and also while idle. It is high in the cycle after an acknowledge when more words remain.
- R5: The acknowledged count increments by one on each edge where mem_req and mem_ack are both high.
- R6: On the edge that acknowledges the last word, busy clears and done sets. After that, s_ready stays low until the next start.
- R7: While busy, writes to the address, count and control registers are ignored. This includes a start write that lands in the same cycle as the last acknowledge.
- R8: After reset, all registers read 0, and s_ready and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| s_valid | input | 1 | Stream beat valid |
| s_data | input | 32 | Stream beat data |
| s_ready | output | 1 | Stream ready (back-pressure) |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 20 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |

## Verification
The acknowledge of the final word and a software start write can land on the same clock edge. The bench provokes this by waiting until the model shows the last request pending, then pulsing the start write in the cycle the acknowledge is driven. The start must be dropped: afterwards done reads 1, busy reads 0 and the count equals the programmed length. A second overlap is an acknowledge followed at once by a new beat. The per-clock model expects s_ready to return exactly one cycle after each acknowledge, checked under both immediate and irregular acknowledge patterns.

// File: rtl/stwa_pkg.sv
package stwa_pkg;

    typedef enum logic [1:0] {
        OFF_CTRL  = 2'd0,
        OFF_DEST  = 2'd1,
        OFF_LEN   = 2'd2,
        OFF_COUNT = 2'd3
    } reg_off_e;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_BUSY_BIT  = 1;
    localparam int CTRL_DONE_BIT  = 2;

endpackage

// File: rtl/stwa_regs.sv
module stwa_regs
    import stwa_pkg::*;
#(
    parameter int              RAW  = 16,
    parameter int              RDW  = 32,
    parameter int              AW   = 20,
    parameter int              LW   = 16,
    parameter logic [RAW-1:0]  BASE = 16'h5200
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [RDW-1:0] reg_wdata,
    output logic [RDW-1:0] reg_rdata,
    input  logic           busy,
    input  logic           done,
    input  logic [LW-1:0]  count,
    output logic [AW-1:0]  dest_addr,
    output logic [LW-1:0]  length,
    output logic           start_cmd
);

    typedef struct packed {
        logic [AW-1:0] dest;
        logic [LW-1:0] len;
    } regs_t;

    regs_t    regs_q, regs_d;
    logic     hit;
    reg_off_e off;
    logic     wr_ok;

    always_comb begin
        hit       = (reg_addr[RAW-1:2] == BASE[RAW-1:2]);
        off       = reg_off_e'(reg_addr[1:0]);
        wr_ok     = reg_wr & hit & ~busy;
        regs_d    = regs_q;
        start_cmd = 1'b0;
        if (wr_ok) begin
            case (off)
                OFF_CTRL: start_cmd  = reg_wdata[CTRL_START_BIT];
                OFF_DEST: regs_d.dest = reg_wdata[AW-1:0];
                OFF_LEN:  regs_d.len  = reg_wdata[LW-1:0];
                default:  regs_d      = regs_q;
            endcase
        end
        reg_rdata = '0;
        if (hit) begin
            case (off)
                OFF_CTRL: begin
                    reg_rdata[CTRL_BUSY_BIT] = busy;
                    reg_rdata[CTRL_DONE_BIT] = done;
                end
                OFF_DEST:  reg_rdata = RDW'(regs_q.dest);
                OFF_LEN:   reg_rdata = RDW'(regs_q.len);
                OFF_COUNT: reg_rdata = RDW'(count);
                default:   reg_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign dest_addr = regs_q.dest;
    assign length    = regs_q.len;

endmodule

// File: rtl/stwa_seq.sv
module stwa_seq #(
    parameter int DW = 32,
    parameter int AW = 20,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_cmd,
    input  logic [AW-1:0] dest_addr,
    input  logic [LW-1:0] length,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    output logic          s_ready,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          done,
    output logic [LW-1:0] count
);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          req;
        logic [LW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } seq_t;

    seq_t          st_q, st_d;
    logic          room, take, acked, last;
    logic [LW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = st_q.cnt + LW'(1);
        room    = st_q.busy & ~st_q.req & (st_q.cnt != length);
        take    = room & s_valid;
        acked   = st_q.req & mem_ack;
        last    = acked & (cnt_inc == length);
        st_d    = st_q;
        if (acked) begin
            st_d.req = 1'b0;
            st_d.cnt = cnt_inc;
            if (last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
        if (take) begin
            st_d.req  = 1'b1;
            st_d.addr = dest_addr + AW'(st_q.cnt);
            st_d.data = s_data;
        end
        if (start_cmd) begin
            st_d.cnt  = '0;
            st_d.req  = 1'b0;
            st_d.busy = (length != '0);
            st_d.done = (length == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_ready   = room;
    assign mem_req   = st_q.req;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.data;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign count     = st_q.cnt;

endmodule

// File: rtl/stwa_top.sv
module stwa_top #(
    parameter int              RAW  = 16,
    parameter int              RDW  = 32,
    parameter int              DW   = 32,
    parameter int              AW   = 20,
    parameter int              LW   = 16,
    parameter logic [RAW-1:0]  BASE = 16'h5200
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [RDW-1:0] reg_wdata,
    output logic [RDW-1:0] reg_rdata,
    input  logic           s_valid,
    input  logic [DW-1:0]  s_data,
    output logic           s_ready,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ack
);

    logic          start_cmd;
    logic          seq_busy;
    logic          seq_done;
    logic [LW-1:0] seq_cnt;
    logic [AW-1:0] dest_addr;
    logic [LW-1:0] length;

    stwa_regs #(
        .RAW(RAW), .RDW(RDW), .AW(AW), .LW(LW), .BASE(BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (seq_busy),
        .done      (seq_done),
        .count     (seq_cnt),
        .dest_addr (dest_addr),
        .length    (length),
        .start_cmd (start_cmd)
    );

    stwa_seq #(
        .DW(DW), .AW(AW), .LW(LW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cmd (start_cmd),
        .dest_addr (dest_addr),
        .length    (length),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_ready   (s_ready),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .busy      (seq_busy),
        .done      (seq_done),
        .count     (seq_cnt)
    );

endmodule

// File: rtl/stwa_chk.sv
module stwa_chk #(
    parameter int DW = 32,
    parameter int AW = 20,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_ready,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          busy,
    input logic          done,
    input logic [LW-1:0] count,
    input logic          start_cmd
);

    p_ready_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !s_ready);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    p_busy_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (count == LW'($past(count) + LW'(1))));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!s_ready && !mem_req));

    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd |=> (count == '0));

endmodule

bind stwa_top stwa_chk #(.DW(DW), .AW(AW), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ready   (s_ready),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (seq_busy),
    .done      (seq_done),
    .count     (seq_cnt),
    .start_cmd (start_cmd)
);

// File: tb/tb_stwa_top.sv
module tb_stwa_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'h5200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = 16'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = 32'h1000_0000;
    logic        s_ready;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int valid_mode = 2;   // 0 always, 1 irregular, 2 off
    int ack_mode = 0;     // 0 immediate, 1 irregular
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference state
    bit   m_busy, m_done, m_req, m_took;
    int   m_cnt, m_len, m_dest;
    logic [51:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    stwa_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
        .s_data(s_data), .s_ready(s_ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [15:0] a);
        logic [31:0] v = 32'h0;
        if (a[15:2] == BASE[15:2]) begin
            case (a[1:0])
                2'd0: v = {29'h0, m_done, m_busy, 1'b0};
                2'd1: v = 32'(m_dest);
                2'd2: v = 32'(m_len);
                default: v = 32'(m_cnt);
            endcase
        end
        return v;
    endfunction

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_req = 0; m_took = 0;
            m_cnt = 0; m_len = 0; m_dest = 0;
            exp_q.delete();
        end else begin
            bit rdy, acc, ack, was_busy;
            rdy = m_busy && !m_req && (m_cnt < m_len);
            acc = rdy && s_valid;
            ack = m_req && mem_ack;
            was_busy = m_busy;
            m_took = acc;
            if (ack) begin
                m_req = 0;
                void'(exp_q.pop_front());
                m_cnt++;
                if (m_cnt == m_len) begin m_busy = 0; m_done = 1; end
            end
            if (acc) begin
                m_req = 1;
                exp_q.push_back({20'((m_dest + m_cnt) % (1 << 20)), s_data});
            end
            if (reg_wr && !was_busy && reg_addr[15:2] == BASE[15:2]) begin
                case (reg_addr[1:0])
                    2'd0: if (reg_wdata[0]) begin
                        m_cnt = 0;
                        m_done = (m_len == 0);
                        m_busy = (m_len != 0);
                    end
                    2'd1: m_dest = int'(reg_wdata[19:0]);
                    2'd2: m_len = int'(reg_wdata[15:0]);
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R4 s_ready", 32'(s_ready), 32'(m_busy && !m_req && (m_cnt < m_len)));
            chk("R3 mem_req", 32'(mem_req), 32'(m_req));
            if (m_req && exp_q.size() > 0) begin
                chk("R3 mem_addr", 32'(mem_addr), 32'(exp_q[0][51:32]));
                chk("R3 mem_wdata", mem_wdata, exp_q[0][31:0]);
            end
            chk("R1 reg_rdata", reg_rdata, exp_rd(reg_addr));
        end
    end

    // stimulus drivers: producer and memory
    always @(negedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (m_took) s_data = s_data + 32'h0103_0507;
        case (valid_mode)
            0: s_valid = 1'b1;
            1: s_valid = lfsr[0];
            default: s_valid = 1'b0;
        endcase
        if (ack_mode == 0) mem_ack = mem_req;
        else               mem_ack = mem_req & lfsr[3];
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk); #1;
        reg_addr = a;
        #2;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wait_idle(input int limit);
        int n = 0;
        @(posedge clk); #1;
        while (m_busy && n < limit) begin
            @(posedge clk); #1;
            n++;
        end
        if (n >= limit) chk("R6 completion timeout", 32'(m_busy), 32'h0);
    endtask

    task automatic run(input int dest, input int len, input int vm, input int am);
        wr(BASE + 16'd1, 32'(dest));
        wr(BASE + 16'd2, 32'(len));
        ack_mode = am;
        wr(BASE, 32'h1);
        valid_mode = vm;
        wait_idle(5000);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R8 reset state
        rd("R8 ctrl after reset", BASE, 32'h0);
        rd("R8 dest after reset", BASE + 16'd1, 32'h0);
        rd("R8 len after reset", BASE + 16'd2, 32'h0);
        rd("R8 count after reset", BASE + 16'd3, 32'h0);
        chk("R8 s_ready after reset", 32'(s_ready), 32'h0);
        chk("R8 mem_req after reset", 32'(mem_req), 32'h0);

        // R1 out-of-window accesses
        wr(16'h5301, 32'h0000_0123);
        rd("R1 dest untouched by foreign write", BASE + 16'd1, 32'h0);
        rd("R1 foreign read is zero", 16'h5205, 32'h0);

        // R2 zero length completes at once
        wr(BASE + 16'd2, 32'h0);
        valid_mode = 0;
        wr(BASE, 32'h1);
        repeat (3) @(negedge clk);
        rd("R2 zero length done", BASE, 32'h4);
        chk("R2 zero length no ready", 32'(s_ready), 32'h0);
        valid_mode = 2;

        // R3 R5 R6 basic transfer with immediate acknowledge
        run(32'h100, 5, 0, 0);
        rd("R5 count equals length", BASE + 16'd3, 32'd5);
        rd("R6 done set busy clear", BASE, 32'h4);
        chk("R6 extra beats blocked", 32'(s_ready), 32'h0);

        // R4 irregular producer and slow memory
        run(32'h2000, 12, 1, 1);
        rd("R5 count after irregular run", BASE + 16'd3, 32'd12);

        // R3 address wraps at 2^20
        run(32'hFFFFE, 4, 0, 1);
        rd("R3 wrap run complete", BASE + 16'd3, 32'd4);

        // R7 writes while busy are ignored
        wr(BASE + 16'd1, 32'h300);
        wr(BASE + 16'd2, 32'd6);
        ack_mode = 1;
        wr(BASE, 32'h1);
        valid_mode = 1;
        wr(BASE + 16'd2, 32'd2);
        wr(BASE + 16'd1, 32'h777);
        rd("R7 len held while busy", BASE + 16'd2, 32'd6);
        rd("R7 dest held while busy", BASE + 16'd1, 32'h300);
        wait_idle(5000);
        rd("R7 count uses original length", BASE + 16'd3, 32'd6);

        // R7 start coinciding with last acknowledge
        wr(BASE + 16'd2, 32'd3);
        ack_mode = 0;
        valid_mode = 0;
        wr(BASE, 32'h1);
        @(posedge clk); #1;
        while (!(m_req && m_cnt == m_len - 1)) begin
            @(posedge clk); #1;
        end
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = BASE; reg_wdata = 32'h1;
        @(negedge clk); #1;
        reg_wr = 1'b0;
        rd("R7 start dropped at last ack", BASE, 32'h4);
        rd("R7 count kept at last ack", BASE + 16'd3, 32'd3);

        // R2 restart clears count and done
        wr(BASE + 16'd2, 32'd2);
        valid_mode = 2;
        wr(BASE, 32'h1);
        rd("R2 restart busy", BASE, 32'h2);
        rd("R2 restart count cleared", BASE + 16'd3, 32'h0);
        valid_mode = 0;
        wait_idle(5000);
        rd("R6 restart done", BASE, 32'h4);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule